// File: doc/BRIEF.md
# Two-Vector CORDIC Phase Difference Detector

This block measures the phase of one complex baseband signal relative to another. Each clock it may accept a pair of vectors, a cavity pickup and a forward-power sample, each given as signed in-phase and quadrature components. It returns the wrapped angle of the cavity vector minus the angle of the forward vector. The result goes to a frequency regulation loop, which works to a few hertz over a range of a few hundred kilohertz, so the angle must be fine-grained and the delay must be fixed.

Two vectoring-mode CORDIC engines run side by side, one per input vector. Each engine first folds its vector into the right half-plane with a ±90° step chosen by the sign of I. It then performs 16 micro-rotations, two per pipeline register, and these drive the quadrature component to zero while an angle accumulator gathers the rotation applied. Angles are 24-bit two's-complement binary fractions of a full turn. The final subtraction therefore wraps through ±180° by plain modular arithmetic. The pipeline takes one new pair every cycle and returns each result a fixed 10 cycles later, which is 125 ns at an 80 MHz clock and inside a 200 ns budget.

Top module: `phase_diff_detector`

## Requirements
- R1: When `out_valid` is high, `phase_out` is the angle of (cav_i, cav_q) minus the angle of (fwd_i, fwd_q). It is a 24-bit two's-complement fraction of a full turn: 1 LSB is 2^-24 turn and 24'h400000 is +90°. For input magnitudes of at least 4096 it lies within ±1000 LSB of the exact value.
- R2: The difference wraps modulo one turn into [-180°, +180°). For example, cavity at +170° and forward at -170° gives about -20° (24'hF1C71C), not +340°.
- R3: Inputs in all four quadrants and on all four axes are handled, including I = -32768 or Q = -32768, without internal overflow.
- R4: Two equal input vectors give a result within ±1000 LSB of zero, for any angle and scale.
- R5: Swapping the cavity and forward inputs negates the result modulo 2^24, to within the R1 tolerance.
- R6: Each cycle with `in_valid` high produces exactly one `out_valid` pulse exactly 10 cycles later, and accepted pairs may arrive on consecutive cycles. The pipeline runs 16 micro-rotations, and 10 cycles at 80 MHz fits within 200 ns.
- R7: While `out_valid` is low, `phase_out` keeps the last result.
- R8: While `rst_n` is low, and in the cycle after it rises, `out_valid` is 0 and `phase_out` is 0. Samples offered during reset produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A vector pair is present this cycle |
| cav_i | input | 16 | Cavity in-phase component, signed |
| cav_q | input | 16 | Cavity quadrature component, signed |
| fwd_i | input | 16 | Forward in-phase component, signed |
| fwd_q | input | 16 | Forward quadrature component, signed |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| phase_out | output | 24 | Cavity angle minus forward angle, in turns times 2^24 |

## Verification
The convergence and sign assertions assume that neither input vector is zero and that the full 16-bit input range is used only as signed values. A zero vector has no angle, so the quadrature residual bound would still hold, but the result would carry no meaning. The stimulus builds every vector from a real angle and a magnitude between 4096 and 32767, with exact axis values such as -32768 added separately. No pair ever has a null component on both axes. The reference model works from the rounded integers actually driven, so input quantization never shows up as design error.

// File: rtl/phdet_pkg.sv
// Package: shared angle width and the per-iteration arctangent constants.
// Assumes angles are binary fractions of one turn held in ANG_W bits.
package phdet_pkg;
    localparam int ANG_W = 24;
    localparam logic [ANG_W-1:0] QUARTER_TURN = 24'h400000;

    // Returns atan(2^-k) scaled to turns times 2^24, for k = 0..15.
    function automatic logic [ANG_W-1:0] atan_step(input int k);
        case (k)
            0:  atan_step = 24'd2097152;
            1:  atan_step = 24'd1238021;
            2:  atan_step = 24'd654136;
            3:  atan_step = 24'd332050;
            4:  atan_step = 24'd166669;
            5:  atan_step = 24'd83416;
            6:  atan_step = 24'd41718;
            7:  atan_step = 24'd20860;
            8:  atan_step = 24'd10430;
            9:  atan_step = 24'd5215;
            10: atan_step = 24'd2608;
            11: atan_step = 24'd1304;
            12: atan_step = 24'd652;
            13: atan_step = 24'd326;
            14: atan_step = 24'd163;
            15: atan_step = 24'd81;
            default: atan_step = '0;
        endcase
    endfunction
endpackage

// File: rtl/cordic_prerot.sv
// Module: cordic_prerot
// Sign-extends a DW-bit vector into XW bits, appends GUARD fraction bits and
// folds it into the right half-plane with a +/-90 degree step. It seeds the
// angle accumulator with the turn removed. One register stage.
// Assumes XW >= DW + GUARD + 2 so that negation and later gain cannot overflow.
module cordic_prerot
    import phdet_pkg::*;
#(
    parameter int DW    = 16,
    parameter int GUARD = 6,
    parameter int XW    = DW + GUARD + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic [DW-1:0]        i_i,
    input  logic [DW-1:0]        q_i,
    output logic                 v_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic [ANG_W-1:0]     z_o
);
    localparam int EXT = XW - DW - GUARD;

    logic signed [XW-1:0] xe, ye;

    // Widen each component and scale it up by the guard bits.
    assign xe = $signed({{EXT{i_i[DW-1]}}, i_i, {GUARD{1'b0}}});
    assign ye = $signed({{EXT{q_i[DW-1]}}, q_i, {GUARD{1'b0}}});

    // Register the half-plane fold and its angle seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                if (xe < 0) begin
                    if (ye >= 0) begin
                        x_o <= ye;
                        y_o <= -xe;
                        z_o <= QUARTER_TURN;
                    end else begin
                        x_o <= -ye;
                        y_o <= xe;
                        z_o <= -QUARTER_TURN;
                    end
                end else begin
                    x_o <= xe;
                    y_o <= ye;
                    z_o <= '0;
                end
            end
        end
    end

    // R3: after the fold the in-phase part is never negative.
    assert_prerot_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> (x_o >= 0));
endmodule

// File: rtl/cordic_stage.sv
// Module: cordic_stage
// Performs COUNT vectoring micro-rotations, starting at shift FIRST, and then
// one register. The rotation direction is taken from the sign of y, so y is
// driven toward zero while z gathers the angle that was applied.
// Assumes the input x is non-negative and FIRST + COUNT <= 16.
module cordic_stage
    import phdet_pkg::*;
#(
    parameter int XW    = 24,
    parameter int FIRST = 0,
    parameter int COUNT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [XW-1:0] x_i,
    input  logic signed [XW-1:0] y_i,
    input  logic [ANG_W-1:0]     z_i,
    output logic                 v_o,
    output logic signed [XW-1:0] x_o,
    output logic signed [XW-1:0] y_o,
    output logic [ANG_W-1:0]     z_o
);
    logic signed [XW-1:0] xs [COUNT+1];
    logic signed [XW-1:0] ys [COUNT+1];
    logic [ANG_W-1:0]     zs [COUNT+1];

    assign xs[0] = x_i;
    assign ys[0] = y_i;
    assign zs[0] = z_i;

    // Chain of combinational micro-rotations inside this stage.
    for (genvar k = 0; k < COUNT; k++) begin : g_rot
        localparam int SH = FIRST + k;
        assign xs[k+1] = ys[k][XW-1] ? xs[k] - (ys[k] >>> SH) : xs[k] + (ys[k] >>> SH);
        assign ys[k+1] = ys[k][XW-1] ? ys[k] + (xs[k] >>> SH) : ys[k] - (xs[k] >>> SH);
        assign zs[k+1] = ys[k][XW-1] ? zs[k] - atan_step(SH) : zs[k] + atan_step(SH);
    end

    // Register the stage result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else begin
            v_o <= v_i;
            if (v_i) begin
                x_o <= xs[COUNT];
                y_o <= ys[COUNT];
                z_o <= zs[COUNT];
            end
        end
    end

    // R3: the magnitude path never wraps negative.
    assert_x_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> !x_o[XW-1]);
endmodule

// File: rtl/cordic_vector.sv
// Module: cordic_vector
// A vectoring CORDIC for one input: a half-plane fold, then ITERS/PER_STAGE
// rotation stages. Latency is 1 + ITERS/PER_STAGE cycles, and the output is
// the vector angle in turns times 2^ANG_W.
// Assumes ITERS is a multiple of PER_STAGE and the input is not the zero vector.
module cordic_vector
    import phdet_pkg::*;
#(
    parameter int DW        = 16,
    parameter int GUARD     = 6,
    parameter int ITERS     = 16,
    parameter int PER_STAGE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [DW-1:0]    i_i,
    input  logic [DW-1:0]    q_i,
    output logic             v_o,
    output logic [ANG_W-1:0] z_o
);
    localparam int XW  = DW + GUARD + 2;
    localparam int NST = ITERS / PER_STAGE;
    localparam logic signed [XW-1:0] Y_BOUND = XW'(2048);

    logic                 sv [NST+1];
    logic signed [XW-1:0] sx [NST+1];
    logic signed [XW-1:0] sy [NST+1];
    logic [ANG_W-1:0]     sz [NST+1];

    cordic_prerot #(.DW(DW), .GUARD(GUARD), .XW(XW)) u_prerot (
        .clk(clk), .rst_n(rst_n), .v_i(v_i), .i_i(i_i), .q_i(q_i),
        .v_o(sv[0]), .x_o(sx[0]), .y_o(sy[0]), .z_o(sz[0])
    );

    // One register stage per group of PER_STAGE micro-rotations.
    for (genvar s = 0; s < NST; s++) begin : g_stage
        cordic_stage #(.XW(XW), .FIRST(s * PER_STAGE), .COUNT(PER_STAGE)) u_stage (
            .clk(clk), .rst_n(rst_n),
            .v_i(sv[s]), .x_i(sx[s]), .y_i(sy[s]), .z_i(sz[s]),
            .v_o(sv[s+1]), .x_o(sx[s+1]), .y_o(sy[s+1]), .z_o(sz[s+1])
        );
    end

    assign v_o = sv[NST];
    assign z_o = sz[NST];

    // R1: the quadrature residual has converged near zero at the last stage.
    assert_converged_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sv[NST] |-> (sy[NST] < Y_BOUND && sy[NST] > -Y_BOUND));
    // R3: the final magnitude estimate is non-negative.
    assert_mag_nonneg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sv[NST] |-> (sx[NST] >= 0));
endmodule

// File: rtl/phase_diff_detector.sv
// Module: phase_diff_detector (top)
// Runs two vectoring CORDIC engines in lockstep, one for the cavity vector and
// one for the forward vector. It subtracts their angles modulo one turn and
// registers the result. Fixed latency LATENCY = ITERS/PER_STAGE + 2 cycles.
// Assumes that neither input vector is zero when in_valid is high.
module phase_diff_detector
    import phdet_pkg::*;
#(
    parameter int DW        = 16,
    parameter int GUARD     = 6,
    parameter int ITERS     = 16,
    parameter int PER_STAGE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [DW-1:0]    cav_i,
    input  logic [DW-1:0]    cav_q,
    input  logic [DW-1:0]    fwd_i,
    input  logic [DW-1:0]    fwd_q,
    output logic             out_valid,
    output logic [ANG_W-1:0] phase_out
);
    localparam int LATENCY = ITERS / PER_STAGE + 2;
    localparam int NCH     = 2;

    logic [DW-1:0]    ch_i [NCH];
    logic [DW-1:0]    ch_q [NCH];
    logic             ch_v [NCH];
    logic [ANG_W-1:0] ch_z [NCH];

    assign ch_i[0] = cav_i;
    assign ch_q[0] = cav_q;
    assign ch_i[1] = fwd_i;
    assign ch_q[1] = fwd_q;

    // Channel 0 is the cavity, channel 1 is the forward signal.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        cordic_vector #(.DW(DW), .GUARD(GUARD), .ITERS(ITERS), .PER_STAGE(PER_STAGE)) u_vec (
            .clk(clk), .rst_n(rst_n), .v_i(in_valid),
            .i_i(ch_i[c]), .q_i(ch_q[c]),
            .v_o(ch_v[c]), .z_o(ch_z[c])
        );
    end

    // Modular subtraction of the two angles; wrap-around is free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            phase_out <= '0;
        end else begin
            out_valid <= ch_v[0];
            if (ch_v[0]) phase_out <= ch_z[0] - ch_z[1];
        end
    end

    // R6: both engines deliver results in the same cycle.
    assert_lockstep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_v[0] == ch_v[1]);
    // R6: an engine result always becomes a pulse on the output.
    assert_pulse_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_v[0] |=> out_valid);
    // R7: the result holds between pulses.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(phase_out));
endmodule

// File: tb/phase_diff_detector_bench.sv
`timescale 1ns/1ps
// Bench: a reference model built on a queue. Each driven pair pushes its
// due cycle and its exact phase from $atan2, and the outputs are compared
// at every falling edge.
module phase_diff_detector_bench;
    localparam int  LAT  = 10;
    localparam int  TOL  = 1000;
    localparam real PI_R = 3.14159265358979;

    typedef struct { int due; int expv; int req; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [15:0] cav_i = '0, cav_q = '0, fwd_i = '0, fwd_q = '0;
    logic        out_valid;
    logic [23:0] phase_out;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   checking = 1'b0;
    bit   done = 1'b0;
    logic [23:0] prev_phase = '0;
    exp_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phase_diff_detector u_phase_diff_detector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cav_i(cav_i), .cav_q(cav_q), .fwd_i(fwd_i), .fwd_q(fwd_q),
        .out_valid(out_valid), .phase_out(phase_out)
    );

    function automatic int ref_phase(int ci, int cq, int fi, int fq);
        real d;
        d = ($atan2(real'(cq), real'(ci)) - $atan2(real'(fq), real'(fi))) / (2.0 * PI_R);
        while (d >= 0.5) d = d - 1.0;
        while (d < -0.5) d = d + 1.0;
        return $rtoi(d * 16777216.0);
    endfunction

    task automatic chk(bit ok, int req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // Drive one pair at the next falling edge plus 1 ns and queue its expected result.
    task automatic send(int ci, int cq, int fi, int fq, int req);
        exp_t e;
        @(negedge clk); #1;
        in_valid = 1'b1;
        cav_i = 16'(ci); cav_q = 16'(cq); fwd_i = 16'(fi); fwd_q = 16'(fq);
        e.due = cyc + LAT;
        e.expv = ref_phase(ci, cq, fi, fq);
        e.req = req;
        q.push_back(e);
    endtask

    task automatic send_ang(real ac, real mc, real af, real mf, int req);
        send($rtoi(mc * $cos(ac * PI_R / 180.0)), $rtoi(mc * $sin(ac * PI_R / 180.0)),
             $rtoi(mf * $cos(af * PI_R / 180.0)), $rtoi(mf * $sin(af * PI_R / 180.0)), req);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
            in_valid = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Compare against the model every cycle once checking is on.
    always @(negedge clk) begin
        if (checking) begin
            if (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                logic [23:0] diff;
                int err;
                e = q.pop_front();
                chk(out_valid === 1'b1, 6, "out_valid at due cycle", int'(out_valid), 1);
                diff = phase_out - 24'(e.expv);
                err = int'($signed(diff));
                chk(err <= TOL && err >= -TOL, e.req, "phase",
                    int'($signed(phase_out)), e.expv);
            end else begin
                chk(out_valid === 1'b0, 6, "no stray out_valid", int'(out_valid), 0);
                chk(phase_out === prev_phase, 7, "phase held while idle",
                    int'(phase_out), int'(prev_phase)); // R7
            end
        end
        prev_phase = phase_out;
    end

    initial begin
        #(5.0 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R8: samples offered during reset are dropped and the outputs read zero.
        @(negedge clk); #1;
        in_valid = 1'b1; cav_i = 16'd20000; cav_q = 16'd5000; fwd_i = 16'd9000; fwd_q = 16'd100;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(out_valid === 1'b0, 8, "out_valid in reset", int'(out_valid), 0);
            chk(phase_out === 24'd0, 8, "phase_out in reset", int'(phase_out), 0);
        end
        #1; in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && phase_out === 24'd0, 8, "state after reset release",
            int'(phase_out), 0);
        checking = 1'b1;

        // R4: equal vectors at several angles and scales.
        send_ang(0.0, 20000.0, 0.0, 20000.0, 4);
        send_ang(123.4, 4096.0, 123.4, 4096.0, 4);
        send_ang(-77.0, 32000.0, -77.0, 32000.0, 4);
        idle(3);
        // R1: various differences with unequal magnitudes.
        send_ang(30.0, 30000.0, 0.0, 5000.0, 1);
        send_ang(0.0, 8000.0, 45.0, 25000.0, 1);
        send_ang(100.0, 12000.0, -35.0, 17000.0, 1);
        send_ang(-150.0, 4096.0, 60.0, 32000.0, 1);
        send_ang(0.001, 30000.0, 0.0, 30000.0, 1);
        idle(2);
        // R3: axes, quadrants and the most negative code.
        send(32767, 0, 0, 32767, 3);
        send(-32768, 0, 0, -32768, 3);
        send(0, -32768, -32768, 0, 3);
        send(-20000, -20000, 20000, -20000, 3);
        send(-32768, -32768, 32767, 32767, 3);
        send(-5000, 30000, 5000, -30000, 3);
        idle(4);
        // R2: differences beyond half a turn fold back.
        send_ang(170.0, 20000.0, -170.0, 20000.0, 2);
        send_ang(-170.0, 20000.0, 170.0, 20000.0, 2);
        send_ang(179.9, 15000.0, -179.9, 15000.0, 2);
        send_ang(90.0, 15000.0, -95.0, 15000.0, 2);
        idle(2);
        // R5: swapped pairs give negated results.
        send_ang(40.0, 25000.0, -10.0, 9000.0, 5);
        send_ang(-10.0, 9000.0, 40.0, 25000.0, 5);
        send_ang(-120.0, 6000.0, 135.0, 30000.0, 5);
        send_ang(135.0, 30000.0, -120.0, 6000.0, 5);
        idle(1);
        // R6: long back-to-back stream of varied pairs.
        for (int k = 0; k < 60; k++) begin
            real a1, a2, m1, m2;
            a1 = real'($urandom_range(0, 35999)) / 100.0 - 180.0;
            a2 = real'($urandom_range(0, 35999)) / 100.0 - 180.0;
            m1 = real'($urandom_range(4096, 32767));
            m2 = real'($urandom_range(4096, 32767));
            send_ang(a1, m1, a2, m2, 6);
        end
        // R7: gaps between isolated pairs.
        for (int k = 0; k < 5; k++) begin
            send_ang(real'(k * 50) - 100.0, 18000.0, real'(k * 20), 22000.0, 7);
            idle(k + 1);
        end
        idle(LAT + 5);
        chk(q.size() == 0, 6, "all results delivered", q.size(), 0);
        finish_run();
    end
endmodule